// File: doc/BRIEF.md
# Tile Shape Configuration Controller

This block keeps the shape settings for a bank of eight matrix tile registers. A 512-bit configuration word arrives with a one-cycle load pulse. The word holds a palette number and, for each tile, a row count and a row width in bytes. The block checks every field of the word in one combinational pass. If the word is valid, the block commits it, and the per-tile shapes then drive the compute and load/store paths. If the word is invalid, the block pulses a fault and keeps the settings it already held.

Palette zero is an init request, and so is a separate release pulse. Either one drops the configuration, zeroes all shape outputs and pulses a clear strobe toward the tile data storage. A store pulse returns the active configuration one cycle later, in the same 512-bit layout it was loaded in. While the unit is unconfigured, this read-back is all zeros.

Top module: `tile_cfg_ctrl`

## Requirements
- R1: A load (one-cycle `load_i` pulse) of a valid word whose palette byte (bits 7:0) is 1 commits it. From the next cycle `configured_o` is high, `palette_o` is 1, tile i's row count (word bits 384+8i +: 8) appears on `tile_rows_o[8i +: 8]`, and its bytes per row (word bits 128+16i +: 16, little-endian) appears on `tile_bpr_o[16i +: 16]`.
- R2: A `store_i` pulse gives `store_valid_o` high for exactly the next cycle. In that cycle `store_word_o` holds the configuration as it stood before that clock edge, in the load layout, with every reserved bit zero.
- R3: A load whose palette byte is 0 pulses `clear_o` in the next cycle. It leaves the unit unconfigured with all shape outputs zero, whatever the other bytes hold.
- R4: A palette byte above 1 makes the load invalid.
- R5: A row count above 16 makes the load invalid. Exactly 16 is accepted.
- R6: A bytes-per-row value above 64, or one that is not a multiple of 4, makes the load invalid. Exactly 64 is accepted.
- R7: A tile with a nonzero row count and zero width is invalid, and so is the reverse. A tile with both fields zero is valid.
- R8: A load is invalid if any reserved bit is nonzero. The reserved bits are bytes 1–15, 32–47 and 56–63.
- R9: An invalid load pulses `fault_o` in the next cycle and leaves the configured flag, the palette and every shape output unchanged.
- R10: Read-back while unconfigured returns 512 zero bits.
- R11: A `release_i` pulse gives a `clear_o` pulse in the next cycle and leaves the unit unconfigured with all shape outputs zero.
- R12: `fault_o` and `clear_o` are single-cycle pulses, never high together, and high only in the cycle after a command. When release and load arrive together, release wins and the load is dropped.
- R13: After synchronous reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Load pulse for `load_word_i` |
| load_word_i | input | 512 | Configuration word to validate |
| store_i | input | 1 | Read-back request pulse |
| release_i | input | 1 | Return-to-init pulse |
| fault_o | output | 1 | Invalid-load pulse |
| clear_o | output | 1 | Clear-all-tiles strobe |
| configured_o | output | 1 | A valid nonzero palette is active |
| palette_o | output | 8 | Active palette |
| tile_rows_o | output | 64 | Row count per tile, 8 bits each |
| tile_bpr_o | output | 128 | Bytes per row per tile, 16 bits each |
| store_valid_o | output | 1 | Read-back word valid |
| store_word_o | output | 512 | Read-back configuration word |

## Verification
The following are checked every cycle:
- the pulses only ever follow their causes and never overlap;
- a fault leaves the whole shape state stable;
- a committed shape never exceeds the row and width limits;
- read-back of an unconfigured unit is zero.

Whether a particular field value is accepted or rejected, and the exact round trip from load word to read-back word, can only be shown by the bench's scenarios. These include the boundary values 16 and 64, misaligned widths, half-zero tiles, reserved bytes, palette zero carrying junk, and release arriving with a load.

// File: rtl/tcfg_pkg.sv
package tcfg_pkg;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_COMMIT = 2'd1,
    ACT_INIT   = 2'd2,
    ACT_FAULT  = 2'd3
  } tcfg_act_e;

  // Release overrides a load in the same cycle; palette zero is an init.
  function automatic tcfg_act_e tcfg_decide(input logic load,
                                            input logic rel,
                                            input logic is_init,
                                            input logic is_ok);
    tcfg_act_e a;
    a = ACT_NONE;
    if (rel)           a = ACT_INIT;
    else if (load) begin
      if (is_init)     a = ACT_INIT;
      else if (is_ok)  a = ACT_COMMIT;
      else             a = ACT_FAULT;
    end
    return a;
  endfunction

endpackage

// File: rtl/tcfg_check.sv
module tcfg_check #(
  parameter int CFG_W       = 512,
  parameter int NUM_TILES   = 8,
  parameter int PAL_W       = 8,
  parameter int ROW_W       = 8,
  parameter int BPR_W       = 16,
  parameter int BPR_BYTE    = 16,
  parameter int ROW_BYTE    = 48,
  parameter int MAX_ROWS    = 16,
  parameter int MAX_BPR     = 64,
  parameter int BPR_ALIGN   = 4,
  parameter int MAX_PALETTE = 1
) (
  input  logic [CFG_W-1:0]           word_i,
  output logic                       init_o,
  output logic                       ok_o,
  output logic [PAL_W-1:0]           pal_o,
  output logic [NUM_TILES*ROW_W-1:0] rows_o,
  output logic [NUM_TILES*BPR_W-1:0] bpr_o
);
  localparam int ROW_LSB = ROW_BYTE * 8;
  localparam int BPR_LSB = BPR_BYTE * 8;

  function automatic logic [CFG_W-1:0] field_mask();
    logic [CFG_W-1:0] m;
    m = '0;
    m[PAL_W-1:0] = '1;
    for (int t = 0; t < NUM_TILES; t++) begin
      m[BPR_LSB + t*BPR_W +: BPR_W] = '1;
      m[ROW_LSB + t*ROW_W +: ROW_W] = '1;
    end
    return m;
  endfunction

  localparam logic [CFG_W-1:0] USED_MASK = field_mask();

  logic [NUM_TILES-1:0] tile_bad;
  logic                 rsv_bad;
  logic                 pal_bad;

  for (genvar t = 0; t < NUM_TILES; t++) begin : g_tile
    logic [ROW_W-1:0] r;
    logic [BPR_W-1:0] b;
    logic             r_big, b_big, b_mis, half;
    assign r     = word_i[ROW_LSB + t*ROW_W +: ROW_W];
    assign b     = word_i[BPR_LSB + t*BPR_W +: BPR_W];
    assign r_big = r > ROW_W'(MAX_ROWS);
    assign b_big = b > BPR_W'(MAX_BPR);
    assign b_mis = (b % BPR_W'(BPR_ALIGN)) != '0;
    assign half  = (r == '0) != (b == '0);
    assign tile_bad[t] = r_big | b_big | b_mis | half;
    assign rows_o[t*ROW_W +: ROW_W] = r;
    assign bpr_o[t*BPR_W +: BPR_W]  = b;
  end

  assign pal_o   = word_i[PAL_W-1:0];
  assign rsv_bad = |(word_i & ~USED_MASK);
  assign pal_bad = pal_o > PAL_W'(MAX_PALETTE);
  assign init_o  = (pal_o == '0);
  assign ok_o    = !pal_bad && !rsv_bad && !(|tile_bad);

endmodule

// File: rtl/tcfg_regs.sv
module tcfg_regs
  import tcfg_pkg::*;
#(
  parameter int NUM_TILES = 8,
  parameter int PAL_W     = 8,
  parameter int ROW_W     = 8,
  parameter int BPR_W     = 16,
  parameter int MAX_ROWS  = 16,
  parameter int MAX_BPR   = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load_i,
  input  logic                       release_i,
  input  logic                       init_i,
  input  logic                       ok_i,
  input  logic [PAL_W-1:0]           pal_i,
  input  logic [NUM_TILES*ROW_W-1:0] rows_i,
  input  logic [NUM_TILES*BPR_W-1:0] bpr_i,
  output logic                       configured_o,
  output logic [PAL_W-1:0]           pal_o,
  output logic [NUM_TILES*ROW_W-1:0] rows_o,
  output logic [NUM_TILES*BPR_W-1:0] bpr_o,
  output logic                       fault_o,
  output logic                       clear_o
);
  tcfg_act_e act;
  assign act = tcfg_decide(load_i, release_i, init_i, ok_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      configured_o <= 1'b0;
      pal_o        <= '0;
      rows_o       <= '0;
      bpr_o        <= '0;
      fault_o      <= 1'b0;
      clear_o      <= 1'b0;
    end else begin
      fault_o <= 1'b0;
      clear_o <= 1'b0;
      case (act)
        ACT_COMMIT: begin
          configured_o <= 1'b1;
          pal_o        <= pal_i;
          rows_o       <= rows_i;
          bpr_o        <= bpr_i;
        end
        ACT_INIT: begin
          configured_o <= 1'b0;
          pal_o        <= '0;
          rows_o       <= '0;
          bpr_o        <= '0;
          clear_o      <= 1'b1;
        end
        ACT_FAULT: fault_o <= 1'b1;
        default: ;
      endcase
    end
  end

  assert_fault_after_load_R4: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> $past(load_i && !release_i));

  assert_clear_cause_R11: assert property (@(posedge clk) disable iff (rst)
    clear_o |-> $past(release_i || load_i));

  assert_pulse_excl_R12: assert property (@(posedge clk) disable iff (rst)
    !(fault_o && clear_o));

  assert_fault_holds_R9: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> ($stable(configured_o) && $stable(pal_o) &&
                 $stable(rows_o) && $stable(bpr_o)));

  assert_clear_empties_R3: assert property (@(posedge clk) disable iff (rst)
    clear_o |-> (!configured_o && pal_o == '0 && rows_o == '0 && bpr_o == '0));

  assert_cfg_palette_R1: assert property (@(posedge clk) disable iff (rst)
    configured_o |-> (pal_o != '0));

  for (genvar t = 0; t < NUM_TILES; t++) begin : g_lim
    assert_rows_range_R5: assert property (@(posedge clk) disable iff (rst)
      rows_o[t*ROW_W +: ROW_W] <= ROW_W'(MAX_ROWS));
    assert_bpr_range_R6: assert property (@(posedge clk) disable iff (rst)
      bpr_o[t*BPR_W +: BPR_W] <= BPR_W'(MAX_BPR));
  end

endmodule

// File: rtl/tcfg_readback.sv
module tcfg_readback #(
  parameter int CFG_W     = 512,
  parameter int NUM_TILES = 8,
  parameter int PAL_W     = 8,
  parameter int ROW_W     = 8,
  parameter int BPR_W     = 16,
  parameter int BPR_BYTE  = 16,
  parameter int ROW_BYTE  = 48
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       store_i,
  input  logic                       configured_i,
  input  logic [PAL_W-1:0]           pal_i,
  input  logic [NUM_TILES*ROW_W-1:0] rows_i,
  input  logic [NUM_TILES*BPR_W-1:0] bpr_i,
  output logic                       store_valid_o,
  output logic [CFG_W-1:0]           store_word_o
);
  localparam int ROW_LSB = ROW_BYTE * 8;
  localparam int BPR_LSB = BPR_BYTE * 8;

  logic [CFG_W-1:0] packed_w;

  always_comb begin
    packed_w = '0;
    packed_w[PAL_W-1:0] = pal_i;
    for (int t = 0; t < NUM_TILES; t++) begin
      packed_w[ROW_LSB + t*ROW_W +: ROW_W] = rows_i[t*ROW_W +: ROW_W];
      packed_w[BPR_LSB + t*BPR_W +: BPR_W] = bpr_i[t*BPR_W +: BPR_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      store_valid_o <= 1'b0;
      store_word_o  <= '0;
    end else begin
      store_valid_o <= store_i;
      if (store_i) store_word_o <= configured_i ? packed_w : '0;
    end
  end

  assert_rb_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    store_valid_o |-> $past(store_i));

  assert_rb_empty_R10: assert property (@(posedge clk) disable iff (rst)
    (store_valid_o && !$past(configured_i)) |-> (store_word_o == '0));

endmodule

// File: rtl/tile_cfg_ctrl.sv
module tile_cfg_ctrl #(
  parameter int CFG_W       = 512,
  parameter int NUM_TILES   = 8,
  parameter int PAL_W       = 8,
  parameter int ROW_W       = 8,
  parameter int BPR_W       = 16,
  parameter int BPR_BYTE    = 16,
  parameter int ROW_BYTE    = 48,
  parameter int MAX_ROWS    = 16,
  parameter int MAX_BPR     = 64,
  parameter int BPR_ALIGN   = 4,
  parameter int MAX_PALETTE = 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load_i,
  input  logic [CFG_W-1:0]           load_word_i,
  input  logic                       store_i,
  input  logic                       release_i,
  output logic                       fault_o,
  output logic                       clear_o,
  output logic                       configured_o,
  output logic [PAL_W-1:0]           palette_o,
  output logic [NUM_TILES*ROW_W-1:0] tile_rows_o,
  output logic [NUM_TILES*BPR_W-1:0] tile_bpr_o,
  output logic                       store_valid_o,
  output logic [CFG_W-1:0]           store_word_o
);
  logic                       chk_init, chk_ok;
  logic [PAL_W-1:0]           chk_pal;
  logic [NUM_TILES*ROW_W-1:0] chk_rows;
  logic [NUM_TILES*BPR_W-1:0] chk_bpr;

  tcfg_check #(
    .CFG_W(CFG_W), .NUM_TILES(NUM_TILES), .PAL_W(PAL_W), .ROW_W(ROW_W),
    .BPR_W(BPR_W), .BPR_BYTE(BPR_BYTE), .ROW_BYTE(ROW_BYTE),
    .MAX_ROWS(MAX_ROWS), .MAX_BPR(MAX_BPR), .BPR_ALIGN(BPR_ALIGN),
    .MAX_PALETTE(MAX_PALETTE)
  ) u_check (
    .word_i (load_word_i),
    .init_o (chk_init),
    .ok_o   (chk_ok),
    .pal_o  (chk_pal),
    .rows_o (chk_rows),
    .bpr_o  (chk_bpr)
  );

  tcfg_regs #(
    .NUM_TILES(NUM_TILES), .PAL_W(PAL_W), .ROW_W(ROW_W), .BPR_W(BPR_W),
    .MAX_ROWS(MAX_ROWS), .MAX_BPR(MAX_BPR)
  ) u_regs (
    .clk          (clk),
    .rst          (rst),
    .load_i       (load_i),
    .release_i    (release_i),
    .init_i       (chk_init),
    .ok_i         (chk_ok),
    .pal_i        (chk_pal),
    .rows_i       (chk_rows),
    .bpr_i        (chk_bpr),
    .configured_o (configured_o),
    .pal_o        (palette_o),
    .rows_o       (tile_rows_o),
    .bpr_o        (tile_bpr_o),
    .fault_o      (fault_o),
    .clear_o      (clear_o)
  );

  tcfg_readback #(
    .CFG_W(CFG_W), .NUM_TILES(NUM_TILES), .PAL_W(PAL_W), .ROW_W(ROW_W),
    .BPR_W(BPR_W), .BPR_BYTE(BPR_BYTE), .ROW_BYTE(ROW_BYTE)
  ) u_readback (
    .clk           (clk),
    .rst           (rst),
    .store_i       (store_i),
    .configured_i  (configured_o),
    .pal_i         (palette_o),
    .rows_i        (tile_rows_o),
    .bpr_i         (tile_bpr_o),
    .store_valid_o (store_valid_o),
    .store_word_o  (store_word_o)
  );

endmodule

// File: tb/tile_cfg_ctrl_bench.sv
module tile_cfg_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load_i = 1'b0;
  logic [511:0] load_word_i = '0;
  logic         store_i = 1'b0;
  logic         release_i = 1'b0;
  logic         fault_o, clear_o, configured_o, store_valid_o;
  logic [7:0]   palette_o;
  logic [63:0]  tile_rows_o;
  logic [127:0] tile_bpr_o;
  logic [511:0] store_word_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  tile_cfg_ctrl u_tile_cfg_ctrl (
    .clk(clk), .rst(rst), .load_i(load_i), .load_word_i(load_word_i),
    .store_i(store_i), .release_i(release_i), .fault_o(fault_o),
    .clear_o(clear_o), .configured_o(configured_o), .palette_o(palette_o),
    .tile_rows_o(tile_rows_o), .tile_bpr_o(tile_bpr_o),
    .store_valid_o(store_valid_o), .store_word_o(store_word_o)
  );

  typedef struct {
    int           due;
    string        tag;
    logic         f, c, cfg;
    logic [7:0]   pal;
    logic [63:0]  rows;
    logic [127:0] bpr;
    bit           chk_st;
    logic [511:0] word;
  } exp_t;

  exp_t q[$];
  int   errors = 0, checks = 0, cyc = 0;
  bit   watch = 0, done = 0;

  // independent model of the committed state
  logic         m_cfg = 0;
  logic [7:0]   m_pal = '0;
  logic [63:0]  m_rows = '0;
  logic [127:0] m_bpr = '0;

  function automatic logic [511:0] model_word();
    logic [511:0] w;
    w = '0;
    if (m_cfg) begin
      w[7:0]     = m_pal;
      w[128+:128] = m_bpr;
      w[384+:64]  = m_rows;
    end
    return w;
  endfunction

  task automatic chk(input bit good, input string tag, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: one command cycle, expectation pushed to the scoreboard
  task automatic cmd(input logic ld, input logic st, input logic rl,
                     input logic [511:0] w, input bit ok, input string tag);
    exp_t e;
    @(negedge clk);
    load_i = ld; store_i = st; release_i = rl; load_word_i = w;
    e.due = cyc + 1; e.tag = tag; e.f = 0; e.c = 0;
    e.chk_st = st; e.word = model_word();
    if (rl || (ld && w[7:0] == 8'd0)) begin
      m_cfg = 0; m_pal = '0; m_rows = '0; m_bpr = '0; e.c = 1;
    end else if (ld) begin
      if (ok) begin
        m_cfg = 1; m_pal = w[7:0]; m_rows = w[384+:64]; m_bpr = w[128+:128];
      end else e.f = 1;
    end
    e.cfg = m_cfg; e.pal = m_pal; e.rows = m_rows; e.bpr = m_bpr;
    q.push_back(e);
    @(negedge clk);
    load_i = 0; store_i = 0; release_i = 0; load_word_i = '0;
  endtask

  // monitor: samples a quarter period after each rising edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      cyc++;
      if (watch) begin
        if (q.size() > 0 && q[0].due == cyc) begin
          e = q.pop_front();
          chk(fault_o == e.f, e.tag, "fault", 512'(fault_o), 512'(e.f));
          chk(clear_o == e.c, e.tag, "clear", 512'(clear_o), 512'(e.c));
          chk(configured_o == e.cfg, e.tag, "configured", 512'(configured_o), 512'(e.cfg));
          chk(palette_o == e.pal, e.tag, "palette", 512'(palette_o), 512'(e.pal));
          chk(tile_rows_o == e.rows, e.tag, "rows", 512'(tile_rows_o), 512'(e.rows));
          chk(tile_bpr_o == e.bpr, e.tag, "bpr", 512'(tile_bpr_o), 512'(e.bpr));
          chk(store_valid_o == e.chk_st, e.tag, "store_valid", 512'(store_valid_o), 512'(e.chk_st));
          if (e.chk_st)
            chk(store_word_o == e.word, e.tag, "store_word", store_word_o, e.word);
        end else begin
          // R12: no pulse without a command in the previous cycle
          chk(!fault_o && !clear_o && !store_valid_o, "R12", "idle pulses",
              {fault_o, clear_o, store_valid_o}, '0);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [511:0] base_word();
    logic [511:0] w;
    w = '0;
    w[7:0] = 8'd1;
    w[384+0*8 +: 8]   = 8'd16;  w[128+0*16 +: 16] = 16'd64;  // boundaries R5 R6
    w[384+1*8 +: 8]   = 8'd3;   w[128+1*16 +: 16] = 16'd12;
    w[384+2*8 +: 8]   = 8'd1;   w[128+2*16 +: 16] = 16'd4;
    w[384+7*8 +: 8]   = 8'd9;   w[128+7*16 +: 16] = 16'd40;
    return w;                                                 // tiles 3..6 empty: R7
  endfunction

  initial begin
    logic [511:0] w;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    // R13 reset state
    chk(!fault_o && !clear_o && !configured_o && !store_valid_o, "R13", "flags",
        {fault_o, clear_o, configured_o, store_valid_o}, '0);
    chk(palette_o == 0 && tile_rows_o == 0 && tile_bpr_o == 0, "R13", "shape",
        {palette_o, tile_rows_o, tile_bpr_o}, '0);
    chk(store_word_o == '0, "R13", "store_word", store_word_o, '0);
    watch = 1;

    cmd(0, 1, 0, '0, 1, "R10 unconfigured readback");
    cmd(1, 0, 0, base_word(), 1, "R1 R5 R6 R7 valid commit");
    cmd(0, 1, 0, '0, 1, "R2 readback");

    w = base_word(); w[7:0] = 8'd2;
    cmd(1, 0, 0, w, 0, "R4 palette 2");
    w = base_word(); w[384+3*8 +: 8] = 8'd17; w[128+3*16 +: 16] = 16'd8;
    cmd(1, 0, 0, w, 0, "R5 rows 17");
    w = base_word(); w[128+2*16 +: 16] = 16'd68;
    cmd(1, 0, 0, w, 0, "R6 bpr 68");
    w = base_word(); w[128+2*16 +: 16] = 16'd6;
    cmd(1, 0, 0, w, 0, "R6 bpr 6 misaligned");
    w = base_word(); w[384+4*8 +: 8] = 8'd4;
    cmd(1, 0, 0, w, 0, "R7 rows without width");
    w = base_word(); w[128+5*16 +: 16] = 16'd8;
    cmd(1, 0, 0, w, 0, "R7 width without rows");
    w = base_word(); w[5*8 +: 8] = 8'h01;
    cmd(1, 0, 0, w, 0, "R8 reserved byte 5");
    w = base_word(); w[60*8 +: 8] = 8'h80;
    cmd(1, 0, 0, w, 0, "R8 reserved byte 60");
    w = base_word(); w[40*8 +: 8] = 8'h10;
    cmd(1, 0, 0, w, 0, "R8 reserved byte 40");
    cmd(0, 1, 0, '0, 1, "R9 R2 readback after faults");

    w = '0; w[7:0] = 8'd1; w[384+6*8 +: 8] = 8'd2; w[128+6*16 +: 16] = 16'd32;
    cmd(1, 1, 0, w, 1, "R2 store with load returns old state");
    cmd(0, 1, 0, '0, 1, "R2 readback of new state");

    w = base_word(); w[7:0] = 8'd0; w[9*8 +: 8] = 8'hAA;
    cmd(1, 0, 0, w, 1, "R3 palette zero init");
    cmd(0, 1, 0, '0, 1, "R10 readback after init");

    cmd(1, 0, 0, base_word(), 1, "R1 recommit");
    cmd(0, 0, 1, '0, 1, "R11 release");
    cmd(0, 1, 0, '0, 1, "R10 readback after release");
    cmd(1, 0, 1, base_word(), 1, "R12 release wins over load");
    cmd(0, 1, 0, '0, 1, "R12 readback after release plus load");

    repeat (4) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule